// File: doc/BRIEF.md
# Multi-Tile Inner-Product Projection Engine

This block performs the projection step of a nearest-point training iteration for a two-class support vector machine. The training set is split into disjoint fragments, one per tile. Each tile keeps its fragment in local sample storage. One pass projects every stored sample onto a single direction vector. A tile builds each fixed-point dot product one feature per cycle, so a result takes DIM cycles.

The tiles share one fully pipelined conversion stage. A round-robin slot gives each tile its turn on that stage. The stage turns each exact integer dot product into an IEEE754 single-precision value. Behind it sit two argmax trackers, one for each class label. Each tracker keeps the largest projection seen for its class and the global index of the sample that produced it.

Software loads the direction vector and the samples through plain write ports, pulses `start`, and waits for `done`. The two per-class results then stay on the output registers until the next pass begins.

Top module: `proj_engine`

## Requirements
- R1: Direction element `dir_sel` is written from `dir_val` when `dir_we` is high. Feature `smp_dim` of local sample `smp_loc` in tile `smp_tile` is written from `smp_val` when `smp_we` is high. The same write sets that sample's label from `smp_pos` (1 means class +1, 0 means class -1). The global sample index is `smp_tile*SPT + smp_loc`.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the pass ends. `done` is a single-cycle pulse in the cycle `busy` falls.
- R3: Each sample's projection is the exact two's-complement sum over all dimensions of feature times direction element, with every value a signed PREC-bit number.
- R4: Each projection is converted exactly to IEEE754 single precision. A sum of zero becomes 0x00000000. The conversion is exact while 2*PREC+clog2(DIM) is at most 24.
- R5: For each class, the block reports the largest converted projection and its global index. When values are equal, the lower index wins, whatever order the samples arrive in.
- R6: When no sample of a class is present, that class's valid flag stays low and its maximum and index read zero.
- R7: While busy, exactly one tile holds the shared slot in each cycle. The slot advances to the next tile every cycle in fixed cyclic order, even when the holder has no result ready. A pass therefore ends within SPT*(DIM+NTILE)+8 cycles of `start`.
- R8: `done` rises only after every converted value has left the pipeline and both trackers have absorbed it. The outputs are already final in the `done` cycle.
- R9: While idle and with no `start`, the result outputs hold their values, even while new samples or direction elements are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_we | input | 1 | Direction element write enable |
| dir_sel | input | DW | Direction element number |
| dir_val | input | PREC | Direction element value (signed) |
| smp_we | input | 1 | Sample feature write enable |
| smp_tile | input | TW | Target tile |
| smp_loc | input | LW | Sample slot within the tile |
| smp_dim | input | DW | Feature number |
| smp_val | input | PREC | Feature value (signed) |
| smp_pos | input | 1 | Sample label, 1 = +1, 0 = -1 |
| start | input | 1 | Begin a pass (ignored while busy) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| pos_valid | output | 1 | A +1 sample was seen |
| pos_max | output | 32 | Largest +1 projection, IEEE754 single |
| pos_idx | output | IDXW | Global index of that sample |
| neg_valid | output | 1 | A -1 sample was seen |
| neg_max | output | 32 | Largest -1 projection, IEEE754 single |
| neg_idx | output | IDXW | Global index of that sample |

## Verification
The bench builds the engine with two tiles, four samples per tile, four dimensions and 8-bit features. This gives eight samples and 18-bit sums, so every pass can be checked in full against an integer model. The float model comes from the bench's own double-to-single repacking. The small size also lets the bench reach the extreme products (-128 times -128), all-zero sums, classes that are entirely absent, and ties that span both tiles and arrive out of index order. It also reaches a winning sample in a chosen tile and slot, which exposes any error in the index mapping.

// File: rtl/proj_pkg.sv
package proj_pkg;
  typedef logic [31:0] f32_t;

  // Maps a single-precision value to an unsigned key with the same ordering.
  function automatic logic [31:0] f32_key(input f32_t f);
    return f[31] ? ~f : {1'b1, f[30:0]};
  endfunction
endpackage

// File: rtl/proj_tile.sv
module proj_tile #(
  parameter int DIM  = 4,
  parameter int PREC = 8,
  parameter int SPT  = 4,
  localparam int DW   = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int LW   = (SPT > 1) ? $clog2(SPT) : 1,
  localparam int ACCW = 2 * PREC + ((DIM > 1) ? $clog2(DIM) : 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [LW-1:0]          wr_loc,
  input  logic [DW-1:0]          wr_dim,
  input  logic [PREC-1:0]        wr_feat,
  input  logic                   wr_lab,
  input  logic [DIM*PREC-1:0]    dir_vec,
  input  logic                   start,
  input  logic                   grant,
  output logic                   rvld,
  output logic signed [ACCW-1:0] racc,
  output logic [LW-1:0]          rloc,
  output logic                   rlab,
  output logic                   fin
);
  localparam int AW = (SPT * DIM > 1) ? $clog2(SPT * DIM) : 1;

  logic [PREC-1:0] feat_q [SPT*DIM];
  logic [SPT-1:0]  lab_q;
  logic [AW-1:0]   waddr, raddr;

  assign waddr = AW'(wr_loc) * AW'(DIM) + AW'(wr_dim);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      feat_q[waddr]  <= wr_feat;
      lab_q[wr_loc]  <= wr_lab;
    end
  end

  logic                   run_q, run_n, rvld_q, rvld_n;
  logic [LW-1:0]          loc_q, loc_n;
  logic [DW-1:0]          dim_q, dim_n;
  logic signed [ACCW-1:0] acc_q, acc_n, acc_base;
  logic signed [2*PREC-1:0] prod;

  assign raddr = AW'(loc_q) * AW'(DIM) + AW'(dim_q);
  assign prod  = $signed(feat_q[raddr]) * $signed(dir_vec[dim_q*PREC +: PREC]);

  always_comb begin
    run_n    = run_q;
    loc_n    = loc_q;
    dim_n    = dim_q;
    acc_n    = acc_q;
    rvld_n   = rvld_q;
    acc_base = (dim_q == '0) ? '0 : acc_q;
    if (start) begin
      run_n  = 1'b1;
      loc_n  = '0;
      dim_n  = '0;
      acc_n  = '0;
      rvld_n = 1'b0;
    end else if (run_q) begin
      if (rvld_q) begin
        if (grant) begin
          rvld_n = 1'b0;
          if (loc_q == LW'(SPT - 1)) run_n = 1'b0;
          else                       loc_n = loc_q + 1'b1;
        end
      end else begin
        acc_n = acc_base + ACCW'(prod);
        if (dim_q == DW'(DIM - 1)) begin
          dim_n  = '0;
          rvld_n = 1'b1;
        end else begin
          dim_n = dim_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rvld_q <= 1'b0;
      loc_q  <= '0;
      dim_q  <= '0;
      acc_q  <= '0;
    end else begin
      run_q  <= run_n;
      rvld_q <= rvld_n;
      loc_q  <= loc_n;
      dim_q  <= dim_n;
      acc_q  <= acc_n;
    end
  end

  assign rvld = rvld_q;
  assign racc = acc_q;
  assign rloc = loc_q;
  assign rlab = lab_q[loc_q];
  assign fin  = !run_q;
endmodule

// File: rtl/proj_fconv.sv
module proj_fconv #(
  parameter int ACCW = 18,
  parameter int MW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_v,
  input  logic signed [ACCW-1:0] in_val,
  input  logic [MW-1:0]          in_meta,
  output logic                   out_v,
  output proj_pkg::f32_t         out_f,
  output logic [MW-1:0]          out_meta,
  output logic                   pend
);
  localparam int PW = $clog2(ACCW);

  logic                   v1_q, v2_q, v3_q;
  logic signed [ACCW-1:0] val1_q;
  logic [MW-1:0]          m1_q, m2_q, m3_q;
  logic                   sgn2_q;
  logic [ACCW-1:0]        mag2_q, mag_n;
  logic [PW-1:0]          pos2_q, pos_n;
  proj_pkg::f32_t         f3_q, f_n;
  logic [23:0]            norm;

  // stage 2 input: sign split and leading-one search
  always_comb begin
    mag_n = val1_q[ACCW-1] ? ACCW'(-val1_q) : ACCW'(val1_q);
    pos_n = '0;
    for (int i = 0; i < ACCW; i++)
      if (mag_n[i]) pos_n = PW'(i);
  end

  // stage 3 input: normalise and pack
  always_comb begin
    norm = 24'(mag2_q) << (23 - int'(pos2_q));
    if (mag2_q == '0) f_n = 32'h0000_0000;
    else              f_n = {sgn2_q, 8'(127 + int'(pos2_q)), norm[22:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_v;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      val1_q <= in_val;
      m1_q   <= in_meta;
    end
    if (v1_q) begin
      sgn2_q <= val1_q[ACCW-1];
      mag2_q <= mag_n;
      pos2_q <= pos_n;
      m2_q   <= m1_q;
    end
    if (v2_q) begin
      f3_q <= f_n;
      m3_q <= m2_q;
    end
  end

  assign out_v    = v3_q;
  assign out_f    = f3_q;
  assign out_meta = m3_q;
  assign pend     = v1_q | v2_q | v3_q;
endmodule

// File: rtl/proj_argmax.sv
module proj_argmax #(
  parameter int IDXW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_v,
  input  proj_pkg::f32_t   in_f,
  input  logic [IDXW-1:0]  in_idx,
  output logic             has,
  output proj_pkg::f32_t   max_f,
  output logic [IDXW-1:0]  max_idx
);
  logic            has_q, has_n;
  proj_pkg::f32_t  max_q, max_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic [31:0]     k_in, k_cur;

  assign k_in  = proj_pkg::f32_key(in_f);
  assign k_cur = proj_pkg::f32_key(max_q);

  always_comb begin
    has_n = has_q;
    max_n = max_q;
    idx_n = idx_q;
    if (clr) begin
      has_n = 1'b0;
      max_n = '0;
      idx_n = '0;
    end else if (in_v) begin
      if (!has_q || (k_in > k_cur) || ((k_in == k_cur) && (in_idx < idx_q))) begin
        has_n = 1'b1;
        max_n = in_f;
        idx_n = in_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_q <= 1'b0;
      max_q <= '0;
      idx_q <= '0;
    end else begin
      has_q <= has_n;
      max_q <= max_n;
      idx_q <= idx_n;
    end
  end

  assign has     = has_q;
  assign max_f   = max_q;
  assign max_idx = idx_q;
endmodule

// File: rtl/proj_engine.sv
module proj_engine #(
  parameter int NTILE = 2,
  parameter int SPT   = 4,
  parameter int DIM   = 4,
  parameter int PREC  = 8,
  localparam int DW   = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int LW   = (SPT > 1) ? $clog2(SPT) : 1,
  localparam int TW   = (NTILE > 1) ? $clog2(NTILE) : 1,
  localparam int IDXW = (NTILE * SPT > 1) ? $clog2(NTILE * SPT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_we,
  input  logic [DW-1:0]   dir_sel,
  input  logic [PREC-1:0] dir_val,
  input  logic            smp_we,
  input  logic [TW-1:0]   smp_tile,
  input  logic [LW-1:0]   smp_loc,
  input  logic [DW-1:0]   smp_dim,
  input  logic [PREC-1:0] smp_val,
  input  logic            smp_pos,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            pos_valid,
  output logic [31:0]     pos_max,
  output logic [IDXW-1:0] pos_idx,
  output logic            neg_valid,
  output logic [31:0]     neg_max,
  output logic [IDXW-1:0] neg_idx
);
  localparam int ACCW = 2 * PREC + ((DIM > 1) ? $clog2(DIM) : 1);
  localparam int MW   = IDXW + 1;

  logic [DIM*PREC-1:0] dir_q;
  always_ff @(posedge clk) begin
    if (dir_we) dir_q[dir_sel*PREC +: PREC] <= dir_val;
  end

  logic                   busy_q, busy_n, done_q, done_n, go;
  logic [TW-1:0]          ptr_q, ptr_n;
  logic [NTILE-1:0]       grant, rvld, rlab, fin;
  logic signed [ACCW-1:0] racc [NTILE];
  logic [LW-1:0]          rloc [NTILE];
  logic                   pend;

  assign go = start && !busy_q;

  for (genvar t = 0; t < NTILE; t++) begin : g_tile
    assign grant[t] = busy_q && (ptr_q == TW'(t));
    proj_tile #(.DIM(DIM), .PREC(PREC), .SPT(SPT)) u_tile (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (smp_we && (smp_tile == TW'(t))),
      .wr_loc (smp_loc),
      .wr_dim (smp_dim),
      .wr_feat(smp_val),
      .wr_lab (smp_pos),
      .dir_vec(dir_q),
      .start  (go),
      .grant  (grant[t]),
      .rvld   (rvld[t]),
      .racc   (racc[t]),
      .rloc   (rloc[t]),
      .rlab   (rlab[t]),
      .fin    (fin[t])
    );
  end

  // slot mux: the granted tile feeds the shared stage if it has a result
  logic                   sel_v;
  logic signed [ACCW-1:0] sel_val;
  logic [MW-1:0]          sel_meta;
  always_comb begin
    sel_v    = 1'b0;
    sel_val  = '0;
    sel_meta = '0;
    for (int t = 0; t < NTILE; t++) begin
      if (grant[t] && rvld[t]) begin
        sel_v    = 1'b1;
        sel_val  = racc[t];
        sel_meta = {rlab[t], IDXW'(t * SPT) + IDXW'(rloc[t])};
      end
    end
  end

  logic           f_v;
  proj_pkg::f32_t f_val;
  logic [MW-1:0]  f_meta;

  proj_fconv #(.ACCW(ACCW), .MW(MW)) u_fconv (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (sel_v),
    .in_val  (sel_val),
    .in_meta (sel_meta),
    .out_v   (f_v),
    .out_f   (f_val),
    .out_meta(f_meta),
    .pend    (pend)
  );

  logic           c_has [2];
  proj_pkg::f32_t c_max [2];
  logic [IDXW-1:0] c_idx [2];

  for (genvar c = 0; c < 2; c++) begin : g_cls
    proj_argmax #(.IDXW(IDXW)) u_amax (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (go),
      .in_v   (f_v && (f_meta[MW-1] == 1'(c))),
      .in_f   (f_val),
      .in_idx (f_meta[IDXW-1:0]),
      .has    (c_has[c]),
      .max_f  (c_max[c]),
      .max_idx(c_idx[c])
    );
  end

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    ptr_n  = '0;
    if (go) begin
      busy_n = 1'b1;
    end else if (busy_q) begin
      ptr_n = (ptr_q == TW'(NTILE - 1)) ? '0 : ptr_q + 1'b1;
      if ((&fin) && !pend) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      ptr_q  <= ptr_n;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign pos_valid = c_has[1];
  assign pos_max   = c_max[1];
  assign pos_idx   = c_idx[1];
  assign neg_valid = c_has[0];
  assign neg_max   = c_max[0];
  assign neg_idx   = c_idx[0];
endmodule

// File: rtl/proj_engine_chk.sv
module proj_engine_chk #(
  parameter int NTILE = 2,
  parameter int IDXW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            pend,
  input logic [NTILE-1:0] grant,
  input logic            pos_valid,
  input logic [IDXW-1:0] pos_idx,
  input logic [31:0]     pos_max,
  input logic            neg_valid,
  input logic [IDXW-1:0] neg_idx,
  input logic [31:0]     neg_max
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_SLOT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(grant) == 1)); // R7
  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (grant == '0)); // R7
  AST_SLOT_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (grant == {$past(grant[NTILE-2:0]), $past(grant[NTILE-1])})); // R7
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pend && !busy)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pos_max) && $stable(neg_max) && $stable(pos_idx) && $stable(neg_idx))); // R9
  AST_POS_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |-> (pos_idx == '0 && pos_max == '0)); // R6
  AST_NEG_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_valid |-> (neg_idx == '0 && neg_max == '0)); // R6
endmodule

bind proj_engine proj_engine_chk #(.NTILE(NTILE), .IDXW(IDXW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pend     (pend),
  .grant    (grant),
  .pos_valid(pos_valid),
  .pos_idx  (pos_idx),
  .pos_max  (pos_max),
  .neg_valid(neg_valid),
  .neg_idx  (neg_idx),
  .neg_max  (neg_max)
);

// File: tb/proj_engine_test.sv
`timescale 1ns/1ps
module proj_engine_test;
  localparam int NTILE = 2, SPT = 4, DIM = 4, PREC = 8;
  localparam int N = NTILE * SPT;
  localparam int BOUND = SPT * (DIM + NTILE) + 8;

  logic clk = 1'b0;
  logic rst_n;
  logic dir_we, smp_we, smp_pos, start;
  logic [1:0] dir_sel, smp_dim, smp_loc;
  logic [0:0] smp_tile;
  logic [7:0] dir_val, smp_val;
  logic busy, done, pos_valid, neg_valid;
  logic [31:0] pos_max, neg_max;
  logic [2:0] pos_idx, neg_idx;

  always #2.5 clk = ~clk;

  proj_engine #(.NTILE(NTILE), .SPT(SPT), .DIM(DIM), .PREC(PREC)) uut (
    .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .dir_sel(dir_sel), .dir_val(dir_val),
    .smp_we(smp_we), .smp_tile(smp_tile), .smp_loc(smp_loc), .smp_dim(smp_dim),
    .smp_val(smp_val), .smp_pos(smp_pos), .start(start), .busy(busy), .done(done),
    .pos_valid(pos_valid), .pos_max(pos_max), .pos_idx(pos_idx),
    .neg_valid(neg_valid), .neg_max(neg_max), .neg_idx(neg_idx));

  int nchk = 0, nfail = 0;
  int feat [N][DIM];
  int lab  [N];
  int dirv [DIM];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF) - 128;
  endfunction

  function automatic logic [31:0] to_f32(input int v);
    logic [63:0] db;
    if (v == 0) return 32'h0;
    db = $realtobits(real'(v));
    return {db[63], 8'(db[62:52] - 11'd896), db[51:29]};
  endfunction

  task automatic load_all();
    for (int d = 0; d < DIM; d++) begin
      @(negedge clk);
      dir_we = 1'b1; dir_sel = 2'(d); dir_val = 8'(dirv[d]);
    end
    @(negedge clk); dir_we = 1'b0;
    for (int g = 0; g < N; g++) begin
      for (int d = 0; d < DIM; d++) begin
        @(negedge clk);
        smp_we = 1'b1; smp_tile = 1'(g / SPT); smp_loc = 2'(g % SPT);
        smp_dim = 2'(d); smp_val = 8'(feat[g][d]); smp_pos = 1'(lab[g]);
      end
    end
    @(negedge clk); smp_we = 1'b0;
  endtask

  task automatic run_pass(input string tag);
    int v, cyc;
    int bp, bn, ip, in_;
    bit hp, hn, seen;
    hp = 0; hn = 0; bp = 0; bn = 0; ip = 0; in_ = 0;
    for (int g = 0; g < N; g++) begin
      v = 0;
      for (int d = 0; d < DIM; d++) v += feat[g][d] * dirv[d];
      if (lab[g] == 1) begin
        if (!hp || v > bp) begin hp = 1; bp = v; ip = g; end
      end else begin
        if (!hn || v > bn) begin hn = 1; bn = v; in_ = g; end
      end
    end
    load_all();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R2 busy after start"}, busy, 1);
    cyc = 1; seen = 0;
    while (!seen && cyc < 1000) begin
      if (done) seen = 1;
      else begin @(negedge clk); cyc++; end
    end
    chk({tag, " R2 done seen"}, seen, 1);
    chk({tag, " R7 pass latency bound"}, (cyc <= BOUND), 1);
    // R8: results already final in the done cycle
    chk({tag, " R8 busy low at done"}, busy, 0);
    chk({tag, " R6 pos valid"}, pos_valid, hp);
    chk({tag, " R6 neg valid"}, neg_valid, hn);
    chk({tag, " R5 pos idx"}, pos_idx, hp ? ip : 0);
    chk({tag, " R5 neg idx"}, neg_idx, hn ? in_ : 0);
    chk({tag, " R3/R4 pos max"}, pos_max, hp ? to_f32(bp) : 32'h0);
    chk({tag, " R3/R4 neg max"}, neg_max, hn ? to_f32(bn) : 32'h0);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, done, 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        nfail++; nchk++;
        $display("FAIL watchdog: actual %0d expected below %0d", wd, 150000);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] hold_p, hold_n;
    logic [2:0]  hold_ip;
    rst_n = 1'b0; dir_we = 0; smp_we = 0; start = 0; smp_pos = 0;
    dir_sel = 0; dir_val = 0; smp_tile = 0; smp_loc = 0; smp_dim = 0; smp_val = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset done", done, 0);
    chk("R6 reset valids", {pos_valid, neg_valid}, 0);
    chk("R6 reset idx", {pos_idx, neg_idx}, 0);

    // mixed random
    for (int d = 0; d < DIM; d++) dirv[d] = rnd8();
    for (int g = 0; g < N; g++) begin
      lab[g] = g % 2;
      for (int d = 0; d < DIM; d++) feat[g][d] = rnd8();
    end
    run_pass("mixed");

    // R6: only +1 present, then only -1 present
    for (int g = 0; g < N; g++) lab[g] = 1;
    run_pass("R6 only-pos");
    for (int g = 0; g < N; g++) lab[g] = 0;
    run_pass("R6 only-neg");

    // R4: all-zero features give +0.0, ties on lowest index
    for (int g = 0; g < N; g++) begin
      lab[g] = (g >= 3) ? 1 : 0;
      for (int d = 0; d < DIM; d++) feat[g][d] = 0;
    end
    run_pass("R4 zero");

    // R5: extreme equal products in both tiles
    for (int d = 0; d < DIM; d++) dirv[d] = -128;
    for (int g = 0; g < N; g++) begin
      lab[g] = (g == 2 || g == 5) ? 1 : 0;
      for (int d = 0; d < DIM; d++) feat[g][d] = -128;
    end
    run_pass("R5 extreme tie");
    for (int d = 0; d < DIM; d++) dirv[d] = 127;
    run_pass("R5 negative tie");

    // R1: winning sample at tile 1, slot 2 (global index 6)
    for (int d = 0; d < DIM; d++) dirv[d] = 100;
    for (int g = 0; g < N; g++) begin
      lab[g] = 1;
      for (int d = 0; d < DIM; d++) feat[g][d] = (g == 6) ? 100 : 3;
    end
    run_pass("R1 index map");
    chk("R1 winner index", pos_idx, 6);

    // random sweep
    for (int p = 0; p < 12; p++) begin
      for (int d = 0; d < DIM; d++) dirv[d] = rnd8();
      for (int g = 0; g < N; g++) begin
        lab[g] = rnd8() & 1;
        for (int d = 0; d < DIM; d++) feat[g][d] = rnd8();
      end
      run_pass("R3 sweep");
    end

    // R9: idle writes leave results unchanged
    hold_p = pos_max; hold_n = neg_max; hold_ip = pos_idx;
    for (int d = 0; d < DIM; d++) dirv[d] = rnd8();
    for (int g = 0; g < N; g++)
      for (int d = 0; d < DIM; d++) feat[g][d] = rnd8();
    load_all();
    repeat (5) @(negedge clk);
    chk("R9 pos max held", pos_max, hold_p);
    chk("R9 neg max held", neg_max, hold_n);
    chk("R9 pos idx held", pos_idx, hold_ip);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule